// File: doc/BRIEF.md
# Double-Precision Float Comparator

This block compares two 64-bit binary floating-point operands in double-precision format. It reports four flags: less-than, greater-or-equal, equal and unordered. The operands are not split into sign, exponent and fraction fields for the ordering itself. Each bit pattern is read as a signed 64-bit integer and compared as one. The integer result is then corrected in two cases: when both operands are negative, and when the operands are equal, which includes a pair of zeros with opposite signs. NaN detection runs beside the ordered compare, and the two are combined with plain AND gates, so the logic has no data-dependent selection path.

A producer presents both operands together with `in_valid`. The block captures them on that clock edge. The flags appear at the outputs one clock later, qualified by `out_valid`. While `in_valid` stays low the captured operands are kept, so the flags keep their last values.

Top module: `fp64_cmp_unit`

## Requirements
- R1: While `rst_n` is low, `out_valid` is low, and it stays low until an operand pair has been accepted.
- R2: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low after a cycle with `in_valid` low.
- R3: An operand is NaN when bits 62..52 are all ones and bits 51..0 are not all zero. `out_uo` is high exactly when at least one operand is NaN.
- R4: When either operand is NaN, `out_lt`, `out_ge` and `out_eq` are all low.
- R5: When neither operand is NaN, exactly one of `out_lt` and `out_ge` is high.
- R6: `out_eq` is high for bit-identical non-NaN operands and for any two zeros. Whenever `out_eq` is high, `out_ge` is high too.
- R7: Positive zero (all bits zero) and negative zero (only bit 63 set) compare equal in either order, and neither is less than the other.
- R8: When both operands have bit 63 set, the one with the larger magnitude is the smaller value.
- R9: When the signs differ and not both operands are zero, the operand with bit 63 set is the lesser one.
- R10: Infinities (exponent all ones, fraction zero) are ordered: positive infinity is above every finite value and negative infinity is below every finite value. A NaN compared with itself is unordered.
- R11: When the upper 32 bits of the two operands are equal, the lower 32 bits are compared as unsigned numbers, so a set bit 31 counts as a large magnitude.
- R12: While `in_valid` is low, all four flags keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Operand pair present |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand |
| out_valid | output | 1 | Flags are valid |
| out_lt | output | 1 | First operand is less than the second |
| out_ge | output | 1 | First operand is greater than or equal to the second |
| out_eq | output | 1 | Operands are equal |
| out_uo | output | 1 | At least one operand is NaN |

## Verification
Two functions can be active in the same cycle: the NaN mask and the ordered compare. Their effects collide when an operand is NaN whose bit pattern would also order it against the other operand, for example a positive NaN against one, or a negative NaN against negative infinity. The stimulus table holds such pairs. For each of them the bench requires unordered high and all three ordered flags low, and an invariant check applies the same rule to every accepted pair. Zero pairs with opposite signs, in both orders, provoke the second overlap: the equality mask has to cancel a strict integer less-than.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  // Flag bundle carried from the combine stage to the ports.
  typedef struct packed {
    logic lt;
    logic ge;
    logic eq;
    logic uo;
  } fpc_flags_t;
endpackage

// File: rtl/fpc_classify.sv
module fpc_classify #(
  parameter int W     = 64,
  parameter int EXP_W = 11
) (
  input  logic [W-1:0] x,
  output logic         is_nan,
  output logic         is_zero,
  output logic         sign
);
  localparam int FRAC_W = W - 1 - EXP_W;

  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] fr;

  always_comb begin
    ex      = x[W-2 -: EXP_W];
    fr      = x[FRAC_W-1:0];
    sign    = x[W-1];
    is_nan  = (&ex) && (|fr);
    is_zero = ~|x[W-2:0];
  end
endmodule

// File: rtl/fpc_intlt.sv
module fpc_intlt #(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         lt
);
  localparam int HALF = W / 2;

  logic signed [HALF-1:0] a_hi, b_hi;
  logic        [HALF-1:0] a_lo, b_lo;

  always_comb begin
    a_hi = a[W-1:HALF];
    b_hi = b[W-1:HALF];
    a_lo = a[HALF-1:0];
    b_lo = b[HALF-1:0];
    // upper words signed, lower words unsigned
    lt = (a_hi < b_hi) || ((a_hi == b_hi) && (a_lo < b_lo));
  end
endmodule

// File: rtl/fpc_combine.sv
module fpc_combine
  import fpc_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         nan_a,
  input  logic         nan_b,
  input  logic         zero_a,
  input  logic         zero_b,
  input  logic         neg_a,
  input  logic         neg_b,
  input  logic         int_lt,
  output fpc_flags_t   flags
);
  logic same;
  logic both_neg;
  logic ord_lt;
  logic ordered;

  always_comb begin
    same     = (a == b) || (zero_a && zero_b);
    both_neg = neg_a && neg_b;
    ord_lt   = !same && (int_lt != both_neg);
    ordered  = !nan_a && !nan_b;
    flags.lt = ordered && ord_lt;
    flags.ge = ordered && !ord_lt;
    flags.eq = ordered && same;
    flags.uo = !ordered;
  end
endmodule

// File: rtl/fp64_cmp_unit.sv
module fp64_cmp_unit
  import fpc_pkg::*;
#(
  parameter int W     = 64,
  parameter int EXP_W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic         out_valid,
  output logic         out_lt,
  output logic         out_ge,
  output logic         out_eq,
  output logic         out_uo
);
  localparam int NOPS = 2;

  // capture stage: next-state
  logic [W-1:0] a_q, b_q, a_d, b_d;
  logic         v_q, v_d;

  always_comb begin
    v_d = in_valid;
    a_d = in_valid ? in_a : a_q;
    b_d = in_valid ? in_b : b_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      a_q <= '0;
      b_q <= '0;
    end else begin
      v_q <= v_d;
      a_q <= a_d;
      b_q <= b_d;
    end
  end

  // per-operand classification
  logic [W-1:0]    ops    [NOPS];
  logic [NOPS-1:0] nan_v, zero_v, neg_v;

  always_comb begin
    ops[0] = a_q;
    ops[1] = b_q;
  end

  for (genvar k = 0; k < NOPS; k++) begin : g_cls
    fpc_classify #(.W(W), .EXP_W(EXP_W)) cls_i (
      .x      (ops[k]),
      .is_nan (nan_v[k]),
      .is_zero(zero_v[k]),
      .sign   (neg_v[k])
    );
  end

  logic       int_lt;
  fpc_flags_t flg;

  fpc_intlt #(.W(W)) ilt_i (
    .a (a_q),
    .b (b_q),
    .lt(int_lt)
  );

  fpc_combine #(.W(W)) cmb_i (
    .a     (a_q),
    .b     (b_q),
    .nan_a (nan_v[0]),
    .nan_b (nan_v[1]),
    .zero_a(zero_v[0]),
    .zero_b(zero_v[1]),
    .neg_a (neg_v[0]),
    .neg_b (neg_v[1]),
    .int_lt(int_lt),
    .flags (flg)
  );

  always_comb begin
    out_valid = v_q;
    out_lt    = flg.lt;
    out_ge    = flg.ge;
    out_eq    = flg.eq;
    out_uo    = flg.uo;
  end
endmodule

// File: rtl/fpc_cmp_chk.sv
module fpc_cmp_chk #(
  parameter int W     = 64,
  parameter int EXP_W = 11
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [W-1:0] in_a,
  input logic [W-1:0] in_b,
  input logic         out_valid,
  input logic         out_lt,
  input logic         out_ge,
  input logic         out_eq,
  input logic         out_uo
);
  localparam int FRAC_W = W - 1 - EXP_W;

  logic nan_in;
  always_comb
    nan_in = ((&in_a[W-2 -: EXP_W]) && (|in_a[FRAC_W-1:0])) ||
             ((&in_b[W-2 -: EXP_W]) && (|in_b[FRAC_W-1:0]));

  assert_valid_hi_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_lo_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_nan_uo_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_uo == $past(nan_in)));
  assert_nan_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_uo) |-> (!out_lt && !out_ge && !out_eq));
  assert_one_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_uo) |-> $onehot({out_lt, out_ge}));
  assert_eq_ge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_eq) |-> out_ge);
  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable({out_lt, out_ge, out_eq, out_uo}));
endmodule

bind fp64_cmp_unit fpc_cmp_chk #(.W(W), .EXP_W(EXP_W)) chk_i (.*);

// File: tb/fp64_cmp_unit_tb_top.sv
module fp64_cmp_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_a = '0;
  logic [63:0] in_b = '0;
  logic        out_valid, out_lt, out_ge, out_eq, out_uo;
  int          total = 0;
  int          bad = 0;

  always #5 clk = ~clk;

  fp64_cmp_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_lt(out_lt), .out_ge(out_ge),
    .out_eq(out_eq), .out_uo(out_uo)
  );

  // {req tag number, a, b, expected lt ge eq uo}
  localparam int NV = 19;
  localparam logic [139:0] VEC [NV] = '{
    {8'd5,  64'h3FF0000000000000, 64'h4000000000000000, 4'b1000}, // R5 1<2
    {8'd5,  64'h4000000000000000, 64'h3FF0000000000000, 4'b0100}, // R5 2>1
    {8'd6,  64'h3FF0000000000000, 64'h3FF0000000000000, 4'b0110}, // R6 equal
    {8'd7,  64'h0000000000000000, 64'h8000000000000000, 4'b0110}, // R7 +0,-0
    {8'd7,  64'h8000000000000000, 64'h0000000000000000, 4'b0110}, // R7 -0,+0
    {8'd8,  64'hBFF0000000000000, 64'hC000000000000000, 4'b0100}, // R8 -1>-2
    {8'd8,  64'hC000000000000000, 64'hBFF0000000000000, 4'b1000}, // R8 -2<-1
    {8'd9,  64'hBFF0000000000000, 64'h3FF0000000000000, 4'b1000}, // R9 -1<1
    {8'd9,  64'h0000000000000001, 64'h8000000000000001, 4'b0100}, // R9 tiny
    {8'd8,  64'h8000000000000000, 64'h8000000000000001, 4'b0100}, // R8 -0>-tiny
    {8'd10, 64'h7FF0000000000000, 64'h7FEFFFFFFFFFFFFF, 4'b0100}, // R10 +inf
    {8'd10, 64'hFFF0000000000000, 64'hFFEFFFFFFFFFFFFF, 4'b1000}, // R10 -inf
    {8'd10, 64'h0000000000000000, 64'hFFF0000000000000, 4'b0100}, // R10 0>-inf
    {8'd3,  64'h7FF8000000000000, 64'h3FF0000000000000, 4'b0001}, // R3 NaN a
    {8'd3,  64'h3FF0000000000000, 64'h7FF0000000000001, 4'b0001}, // R3 NaN b
    {8'd10, 64'h7FF8000000000000, 64'h7FF8000000000000, 4'b0001}, // R10 NaN self
    {8'd4,  64'hFFF8000000000000, 64'hFFF0000000000000, 4'b0001}, // R4 -NaN
    {8'd11, 64'h3FF0000000000001, 64'h3FF0000000000002, 4'b1000}, // R11 low
    {8'd11, 64'h3FF0000080000000, 64'h3FF0000000000001, 4'b0100}  // R11 bit31
  };

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic string rtag(input logic [7:0] n);
    return $sformatf("R%0d", n);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {out_valid, 4'b0}, {1'b0, 4'b0});
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {out_valid, 4'b0}, 5'b0);

    for (int i = 0; i < NV; i++) begin
      in_valid = 1'b1;
      in_a = VEC[i][131:68];
      in_b = VEC[i][67:4];
      @(negedge clk);
      check(rtag(VEC[i][139:132]), {out_valid, out_lt, out_ge, out_eq, out_uo},
            {1'b1, VEC[i][3:0]});
    end

    // R12 / R2: new operands without in_valid are ignored, flags hold
    in_valid = 1'b1;
    in_a = 64'hC000000000000000;
    in_b = 64'h3FF0000000000000;
    @(negedge clk);
    check("R9", {out_valid, out_lt, out_ge, out_eq, out_uo}, 5'b11000);
    in_valid = 1'b0;
    in_a = 64'h7FF8000000000000;
    in_b = 64'h0000000000000000;
    @(negedge clk);
    check("R2", {out_valid, 4'b0}, 5'b0);
    check("R12", {1'b0, out_lt, out_ge, out_eq, out_uo}, 5'b01000);
    @(negedge clk);
    check("R12", {out_valid, out_lt, out_ge, out_eq, out_uo}, 5'b01000);

    // back-to-back pairs
    in_valid = 1'b1;
    in_a = 64'h8000000000000000;
    in_b = 64'h8000000000000000;
    @(negedge clk);
    check("R6", {out_valid, out_lt, out_ge, out_eq, out_uo}, 5'b10110);

    // R1: reset while valid traffic runs
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", {out_valid, 4'b0}, 5'b0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {out_valid, 4'b0}, 5'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule